// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the next-address engine of a microcoded controller for a bus-based processor. It holds the current micro-state, looks that state up in an internal microcode ROM and, every clock edge, picks the following micro-state from four branch kinds. The kinds are: fall through to the next address, jump to the address carried in the microword, branch on the ALU zero flag, and dispatch on the instruction register's opcode and function fields. Besides choosing the next address, the ROM drives the control word for the current state: an ALU operation code and four register load strobes.

The bus datapath and the ALU sit outside the block. They return the zero flag and the decoded instruction fields. A memory-busy input freezes the sequencer while a memory access is outstanding. The ports carry no data stream, so every pin is a plain level signal with no handshake.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `upc` is 0, the instruction-fetch entry. After reset is released the first micro-state is 0, and that state asserts `ld_ma`.
- R2: Branch kind N (code 0) moves to the current address plus one. The fetch sequence runs from 0 to 1 to 2 this way.
- R3: Branch kind J (code 1) moves to the microword's next-address field unconditionally. Each routine ends by jumping back to 0.
- R4: Branch kind Z (code 2) moves to the next-address field when `alu_zero` is 1, and to the current address plus one when it is 0. The branch-if-zero routine at 16 goes to 18 when taken and to 17 when not taken.
- R5: Branch kind D (code 3) moves to the table target for the instruction fields. Opcode 0 with function 0x20 goes to 8. Opcode 0 with function 0x22 goes to 10. Opcode 0x23 goes to 12, opcode 0x04 goes to 16 and opcode 0x02 goes to 20; for these three the function field is ignored.
- R6: Any field pair not listed in R5 dispatches to the illegal state 2^STATE_W-2 (62 by default). That state jumps to itself until reset.
- R7: While `mem_busy` is 1, `upc` keeps its value whatever the branch kind, zero flag or instruction fields are in that cycle.
- R8: The control outputs follow the current state combinationally. `alu_op` uses these codes: COPY_A=0, COPY_B=1, INC_A_1=2, DEC_A_1=3, INC_A_4=4, DEC_A_4=5, ADD=6, SUB=7. State 2 drives INC_A_4 with `ld_pc`. State 8 drives ADD and state 10 drives SUB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_busy | input | 1 | Holds the micro-state while high |
| alu_zero | input | 1 | ALU zero flag used by branch kind Z |
| ir_opcode | input | 6 | Opcode field of the instruction register |
| ir_funct | input | 6 | Function field of the instruction register |
| upc | output | STATE_W | Current micro-state address |
| alu_op | output | 3 | ALU operation for the current state |
| ld_ir | output | 1 | Load strobe for the instruction register |
| ld_pc | output | 1 | Load strobe for the program counter |
| ld_ma | output | 1 | Load strobe for the memory address register |
| ld_a | output | 1 | Load strobe for the A operand register |

## Verification
The memory hold can fall in the same cycle as a dispatch or as a zero-flag branch. Both have to resolve in favour of the hold. The bench raises `mem_busy` while the state sits at 2, which dispatches, and changes the opcode under it. It does the same at 16, which branches on zero, with `alu_zero` at 1. In each case `upc` must stay put for every held cycle. Once busy drops, the state must go to the target for whatever the fields and flag show in that cycle.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  typedef enum logic [1:0] {
    UBR_N = 2'd0,
    UBR_J = 2'd1,
    UBR_Z = 2'd2,
    UBR_D = 2'd3
  } ubr_e;

  typedef enum logic [2:0] {
    ALU_COPY_A = 3'd0,
    ALU_COPY_B = 3'd1,
    ALU_INC1   = 3'd2,
    ALU_DEC1   = 3'd3,
    ALU_INC4   = 3'd4,
    ALU_DEC4   = 3'd5,
    ALU_ADD    = 3'd6,
    ALU_SUB    = 3'd7
  } alu_e;

  typedef struct packed {
    alu_e alu_op;
    logic ld_ir;
    logic ld_pc;
    logic ld_ma;
    logic ld_a;
  } uctl_t;

  // micro-state entry points
  localparam int ST_FETCH0 = 0;
  localparam int ST_FETCH1 = 1;
  localparam int ST_FETCH2 = 2;
  localparam int ST_ADD    = 8;
  localparam int ST_SUB    = 10;
  localparam int ST_LW0    = 12;
  localparam int ST_LW1    = 13;
  localparam int ST_LW2    = 14;
  localparam int ST_BZ0    = 16;
  localparam int ST_BZ1    = 17;
  localparam int ST_BZ2    = 18;
  localparam int ST_JMP    = 20;

  // dispatch table; lower index wins on overlap
  localparam int N_DISP = 5;
  localparam logic [OPC_W-1:0] D_OPC   [N_DISP] = '{6'h00, 6'h00, 6'h23, 6'h04, 6'h02};
  localparam logic [FN_W-1:0]  D_FN    [N_DISP] = '{6'h20, 6'h22, 6'h00, 6'h00, 6'h00};
  localparam logic             D_USEFN [N_DISP] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam int               D_TGT   [N_DISP] = '{ST_ADD, ST_SUB, ST_LW0, ST_BZ0, ST_JMP};

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input  logic [STATE_W-1:0] addr,
  output ubr_e               ubr,
  output logic [STATE_W-1:0] nxt,
  output uctl_t              ctl
);

  localparam int ST_ILL = (1 << STATE_W) - 2;

  always_comb begin
    ubr = UBR_J;
    nxt = STATE_W'(ST_ILL);
    ctl = '0;
    ctl.alu_op = ALU_COPY_A;
    case (int'(addr))
      ST_FETCH0: begin
        ubr = UBR_N; ctl.ld_ma = 1'b1; ctl.alu_op = ALU_COPY_A;
      end
      ST_FETCH1: begin
        ubr = UBR_N; ctl.ld_ir = 1'b1;
      end
      ST_FETCH2: begin
        ubr = UBR_D; ctl.alu_op = ALU_INC4; ctl.ld_pc = 1'b1;
      end
      ST_ADD: begin
        ubr = UBR_J; nxt = STATE_W'(ST_FETCH0); ctl.alu_op = ALU_ADD; ctl.ld_a = 1'b1;
      end
      ST_SUB: begin
        ubr = UBR_J; nxt = STATE_W'(ST_FETCH0); ctl.alu_op = ALU_SUB; ctl.ld_a = 1'b1;
      end
      ST_LW0: begin
        ubr = UBR_N; ctl.alu_op = ALU_ADD; ctl.ld_ma = 1'b1;
      end
      ST_LW1: begin
        ubr = UBR_N; ctl.alu_op = ALU_COPY_B; ctl.ld_a = 1'b1;
      end
      ST_LW2: begin
        ubr = UBR_J; nxt = STATE_W'(ST_FETCH0); ctl.alu_op = ALU_COPY_A;
      end
      ST_BZ0: begin
        ubr = UBR_Z; nxt = STATE_W'(ST_BZ2); ctl.alu_op = ALU_COPY_A;
      end
      ST_BZ1: begin
        ubr = UBR_J; nxt = STATE_W'(ST_FETCH0);
      end
      ST_BZ2: begin
        ubr = UBR_J; nxt = STATE_W'(ST_FETCH0); ctl.alu_op = ALU_ADD; ctl.ld_pc = 1'b1;
      end
      ST_JMP: begin
        ubr = UBR_J; nxt = STATE_W'(ST_FETCH0); ctl.alu_op = ALU_COPY_B; ctl.ld_pc = 1'b1;
      end
      default: begin
        ubr = UBR_J; nxt = STATE_W'(ST_ILL);
      end
    endcase
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FN_W-1:0]    funct,
  output logic [STATE_W-1:0] target
);

  localparam int ST_ILL = (1 << STATE_W) - 2;

  logic [N_DISP-1:0] hit;

  for (genvar gi = 0; gi < N_DISP; gi++) begin : g_ent
    assign hit[gi] = (opcode == D_OPC[gi]) && (!D_USEFN[gi] || (funct == D_FN[gi]));
  end

  always_comb begin
    target = STATE_W'(ST_ILL);
    for (int i = N_DISP - 1; i >= 0; i--) begin
      if (hit[i]) target = STATE_W'(D_TGT[i]);
    end
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input  logic [STATE_W-1:0] cur,
  input  ubr_e               ubr,
  input  logic [STATE_W-1:0] field,
  input  logic [STATE_W-1:0] disp,
  input  logic               zero,
  output logic [STATE_W-1:0] nxt
);

  logic [STATE_W-1:0] inc;
  assign inc = cur + STATE_W'(1);

  always_comb begin
    unique case (ubr)
      UBR_N:   nxt = inc;
      UBR_J:   nxt = field;
      UBR_Z:   nxt = zero ? field : inc;
      UBR_D:   nxt = disp;
      default: nxt = inc;
    endcase
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_busy,
  input  logic               alu_zero,
  input  logic [5:0]         ir_opcode,
  input  logic [5:0]         ir_funct,
  output logic [STATE_W-1:0] upc,
  output logic [2:0]         alu_op,
  output logic               ld_ir,
  output logic               ld_pc,
  output logic               ld_ma,
  output logic               ld_a
);

  ubr_e               cur_ubr;
  logic [STATE_W-1:0] cur_field;
  uctl_t              cur_ctl;
  logic [STATE_W-1:0] disp_tgt;
  logic [STATE_W-1:0] upc_nxt;
  logic [STATE_W-1:0] state_q;

  useq_rom #(.STATE_W(STATE_W)) u_rom (
    .addr (state_q),
    .ubr  (cur_ubr),
    .nxt  (cur_field),
    .ctl  (cur_ctl)
  );

  useq_dispatch #(.STATE_W(STATE_W)) u_disp (
    .opcode (ir_opcode),
    .funct  (ir_funct),
    .target (disp_tgt)
  );

  useq_next #(.STATE_W(STATE_W)) u_next (
    .cur   (state_q),
    .ubr   (cur_ubr),
    .field (cur_field),
    .disp  (disp_tgt),
    .zero  (alu_zero),
    .nxt   (upc_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= STATE_W'(ST_FETCH0);
    else if (!mem_busy) state_q <= upc_nxt;
  end

  assign upc    = state_q;
  assign alu_op = cur_ctl.alu_op;
  assign ld_ir  = cur_ctl.ld_ir;
  assign ld_pc  = cur_ctl.ld_pc;
  assign ld_ma  = cur_ctl.ld_ma;
  assign ld_a   = cur_ctl.ld_a;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import useq_pkg::*;
#(
  parameter int STATE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               zero,
  input logic [STATE_W-1:0] upc,
  input logic [1:0]         ubr,
  input logic [STATE_W-1:0] field,
  input logic [STATE_W-1:0] disp
);

  p_reset_fetch_r1: assert property (@(posedge clk)
    !rst_n |=> (upc == '0));

  p_seq_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ubr == UBR_N) |=> (upc == STATE_W'($past(upc) + STATE_W'(1))));

  p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ubr == UBR_J) |=> (upc == $past(field)));

  p_zero_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ubr == UBR_Z && zero) |=> (upc == $past(field)));

  p_zero_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ubr == UBR_Z && !zero) |=> (upc == STATE_W'($past(upc) + STATE_W'(1))));

  p_dispatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ubr == UBR_D) |=> (upc == $past(disp)));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(upc));

endmodule

bind useq_top useq_chk #(.STATE_W(STATE_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (mem_busy),
  .zero  (alu_zero),
  .upc   (upc),
  .ubr   (cur_ubr),
  .field (cur_field),
  .disp  (disp_tgt)
);

// File: tb/useq_top_tb.sv
module useq_top_tb;

  localparam int STATE_W = 6;
  localparam int ILL     = (1 << STATE_W) - 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               mem_busy = 1'b0;
  logic               alu_zero = 1'b0;
  logic [5:0]         ir_opcode = '0;
  logic [5:0]         ir_funct = '0;
  logic [STATE_W-1:0] upc;
  logic [2:0]         alu_op;
  logic               ld_ir, ld_pc, ld_ma, ld_a;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  useq_top #(.STATE_W(STATE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_busy(mem_busy), .alu_zero(alu_zero),
    .ir_opcode(ir_opcode), .ir_funct(ir_funct), .upc(upc), .alu_op(alu_op),
    .ld_ir(ld_ir), .ld_pc(ld_pc), .ld_ma(ld_ma), .ld_a(ld_a)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic exp_upc(string req, int exp);
    checks++;
    if (int'(upc) != exp) begin
      errors++;
      $display("FAIL %s upc=%0d expected=%0d", req, upc, exp);
    end
  endtask

  task automatic exp_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic exp_alu(string req, int exp);
    checks++;
    if (int'(alu_op) != exp) begin
      errors++;
      $display("FAIL %s alu_op=%0d expected=%0d", req, alu_op, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mem_busy = 1'b0;
    tick(); tick();
    exp_upc("R1", 0);
    rst_n = 1'b1;
    exp_bit("R1", "ld_ma", ld_ma, 1'b1);
  endtask

  // run fetch from state 0 up to the dispatch state 2
  task automatic to_dispatch(logic [5:0] op, logic [5:0] fn);
    ir_opcode = op; ir_funct = fn;
    tick(); exp_upc("R2", 1);
    exp_bit("R8", "ld_ir", ld_ir, 1'b1);
    tick(); exp_upc("R2", 2);
    exp_alu("R8", 4);
    exp_bit("R8", "ld_pc", ld_pc, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    exp_alu("R8", 0);
  endtask

  task automatic t_fetch_busy();
    ir_opcode = 6'h02; ir_funct = 6'h00;
    tick(); exp_upc("R2", 1);
    mem_busy = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); exp_upc("R7", 1);
    end
    mem_busy = 1'b0;
    tick(); exp_upc("R2", 2);
    tick(); exp_upc("R5", 20);
    tick(); exp_upc("R3", 0);
  endtask

  task automatic t_alu_ops();
    to_dispatch(6'h00, 6'h20);
    tick(); exp_upc("R5", 8); exp_alu("R8", 6);
    tick(); exp_upc("R3", 0);
    to_dispatch(6'h00, 6'h22);
    tick(); exp_upc("R5", 10); exp_alu("R8", 7);
    tick(); exp_upc("R3", 0);
  endtask

  task automatic t_load();
    to_dispatch(6'h23, 6'h15);
    tick(); exp_upc("R5", 12);
    tick(); exp_upc("R2", 13);
    tick(); exp_upc("R2", 14);
    tick(); exp_upc("R3", 0);
  endtask

  task automatic t_branch_zero();
    to_dispatch(6'h04, 6'h3f);
    tick(); exp_upc("R5", 16);
    alu_zero = 1'b1;
    tick(); exp_upc("R4", 18);
    alu_zero = 1'b0;
    tick(); exp_upc("R3", 0);
    to_dispatch(6'h04, 6'h00);
    tick(); exp_upc("R5", 16);
    alu_zero = 1'b0;
    tick(); exp_upc("R4", 17);
    tick(); exp_upc("R3", 0);
  endtask

  task automatic t_illegal();
    to_dispatch(6'h3f, 6'h00);
    tick(); exp_upc("R6", ILL);
    tick(); exp_upc("R6", ILL);
    tick(); exp_upc("R6", ILL);
    do_reset();
    to_dispatch(6'h00, 6'h21);
    tick(); exp_upc("R6", ILL);
    do_reset();
  endtask

  // hold coinciding with dispatch and with a taken zero branch
  task automatic t_busy_overlap();
    to_dispatch(6'h00, 6'h20);
    mem_busy = 1'b1;
    tick(); exp_upc("R7", 2);
    ir_opcode = 6'h04;
    tick(); exp_upc("R7", 2);
    mem_busy = 1'b0;
    tick(); exp_upc("R5", 16);
    mem_busy = 1'b1; alu_zero = 1'b1;
    tick(); exp_upc("R7", 16);
    tick(); exp_upc("R7", 16);
    mem_busy = 1'b0;
    tick(); exp_upc("R4", 18);
    alu_zero = 1'b0;
    tick(); exp_upc("R3", 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_fetch_busy();
    t_alu_ops();
    t_load();
    t_branch_zero();
    t_illegal();
    t_busy_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule